// File: doc/BRIEF.md
# Beamforming Down-Converter Channel

This block turns one stream of real 16-bit IF samples into complex baseband for a single antenna of a beamforming array. A numerically controlled oscillator (a 32-bit phase accumulator driving a quarter-wave sine/cosine table) feeds a complex mixer. A 15-tap symmetric low-pass FIR follows the mixer and keeps one result in every eight accepted samples. Each decimated sample is then rotated by a programmable steering phase and scaled by a programmable gain, so that many channels can be aligned and summed coherently downstream.

Samples arrive with a valid strobe and may have gaps; only strobed samples advance the oscillator and the filter. Software writes the tuning word, the steering phase and the gain through a small write-only register port. The tuning word applies to the next accepted sample. Phase and gain are sampled once per output sample, so a write can never split one output between two settings. The decimation factor must be a power of two.

Top module: `bf_ddc`

## Requirements
- R1: While reset is asserted, and after it is released until the first output, out_vld is 0 and out_i and out_q are 0.
- R2: A 32-bit accumulator adds the tuning word (register address 0) once per accepted sample. The value before the add, bits [31:22], selects angle a. The table gives sin = round(32767*sin(2*pi*a/1024)) and cos = sin(a+256), taken from one quarter-wave table through symmetry.
- R3: The mixer gives I = (x*cos) >>> 15 and Q = (x*(-sin)) >>> 15 for the signed input x.
- R4: The filter uses the last 15 mixer samples, which are zero after reset. Coefficient k (k = 0 is the newest) is 8-|k-7|. The result is the weighted sum shifted right arithmetically by 6.
- R5: out_vld pulses for one cycle once per 8 accepted samples, 5 clock edges after the edge that accepts the 8th. A cycle with in_vld low accepts nothing.
- R6: The steering phase word is the low 10 bits of address 1. With c and s the table values for that word, the rotated pair is ri = (fi*c - fq*s) >>> 15 and rq = (fi*s + fq*c) >>> 15.
- R7: The gain is the low 16 bits of address 2, unsigned Q1.15 (reset value 0x8000). Each output is (r*gain) >>> 15, saturated to the range -32768..32767.
- R8: Phase and gain are sampled together at the edge one cycle before out_vld. A write at any other time has no effect on the sample in flight.
- R9: A tuning word write affects the next accepted sample. Writes to address 3 have no effect.
- R10: out_i and out_q hold their value in every cycle where out_vld is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 1 | Input sample strobe |
| in_data | input | 16 | Signed real IF sample |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | 0 tuning word, 1 steering phase, 2 gain, 3 unused |
| cfg_wdata | input | 32 | Register write data |
| out_vld | output | 1 | Baseband sample strobe |
| out_i | output | 16 | In-phase output, signed |
| out_q | output | 16 | Quadrature output, signed |

## Verification
A wrong decimation count shows at out_vld as a strobe out of step with the model within eight accepted samples. A corrupted accumulator or tap history changes the very next output's I/Q values, since every output depends on all fifteen recent mixer samples. A bad phase or gain snapshot shows on the output that follows the write, and a wrong saturation or rounding edge shows as a one-LSB or full-scale mismatch on the affected sample. The bench compares every cycle against a behavioural model, so any divergence is reported in the cycle it first reaches the ports.

// File: rtl/bf_ddc_pkg.sv
package bf_ddc_pkg;
  typedef enum logic [1:0] {
    CFG_TUNE  = 2'd0,
    CFG_PHASE = 2'd1,
    CFG_GAIN  = 2'd2,
    CFG_NONE  = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/bf_ddc_trig.sv
module bf_ddc_trig #(
  parameter int AW = 10,
  parameter int OW = 16
) (
  input  logic [AW-1:0]        ang,
  output logic signed [OW-1:0] cos_o,
  output logic signed [OW-1:0] sin_o
);
  localparam int  QN   = 1 << (AW-2);
  localparam int  IW   = AW-1;
  localparam real AMP  = real'((1 << (OW-1)) - 1);
  localparam real STEP = 6.283185307179586 / real'(4*QN);

  logic [OW-1:0] qtab [0:QN];

  for (genvar k = 0; k <= QN; k++) begin : g_tab
    assign qtab[k] = OW'($rtoi(AMP * $sin(STEP * real'(k)) + 0.5));
  end

  logic [1:0]    qs, qc;
  logic [AW-3:0] idx;
  logic [IW-1:0] is_s, is_c;

  always_comb begin
    qs    = ang[AW-1 -: 2];
    idx   = ang[AW-3:0];
    qc    = qs + 2'd1;
    is_s  = qs[0] ? IW'(QN) - {1'b0, idx} : {1'b0, idx};
    is_c  = qc[0] ? IW'(QN) - {1'b0, idx} : {1'b0, idx};
    sin_o = qs[1] ? -$signed(qtab[is_s]) : $signed(qtab[is_s]);
    cos_o = qc[1] ? -$signed(qtab[is_c]) : $signed(qtab[is_c]);
  end
endmodule

// File: rtl/bf_ddc_nco_mix.sv
module bf_ddc_nco_mix #(
  parameter int DW  = 16,
  parameter int PHW = 32,
  parameter int AW  = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic [DW-1:0]        in_data,
  input  logic [PHW-1:0]       tune,
  output logic                 mix_vld,
  output logic signed [DW-1:0] mix_i,
  output logic signed [DW-1:0] mix_q
);
  localparam int PW = 2*DW;

  logic [PHW-1:0]       acc_q, acc_d;
  logic signed [DW-1:0] x_q;
  logic [AW-1:0]        ang_q;
  logic                 a_vld_q;
  logic signed [DW-1:0] lo_cos, lo_sin;
  logic signed [PW-1:0] p_i, p_q;

  bf_ddc_trig #(.AW(AW), .OW(DW)) i_lo (.ang(ang_q), .cos_o(lo_cos), .sin_o(lo_sin));

  always_comb begin
    acc_d = in_vld ? acc_q + tune : acc_q;
    p_i   = PW'(x_q) * PW'(lo_cos);
    p_q   = PW'(x_q) * PW'(-lo_sin);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      x_q     <= '0;
      ang_q   <= '0;
      a_vld_q <= 1'b0;
      mix_vld <= 1'b0;
      mix_i   <= '0;
      mix_q   <= '0;
    end else begin
      acc_q   <= acc_d;
      a_vld_q <= in_vld;
      mix_vld <= a_vld_q;
      if (in_vld) begin
        x_q   <= $signed(in_data);
        ang_q <= acc_q[PHW-1 -: AW];
      end
      if (a_vld_q) begin
        mix_i <= DW'(p_i >>> (DW-1));
        mix_q <= DW'(p_q >>> (DW-1));
      end
    end
  end

  // R2
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(acc_q));
endmodule

// File: rtl/bf_ddc_fir_dec.sv
module bf_ddc_fir_dec #(
  parameter int DW  = 16,
  parameter int DEC = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mix_vld,
  input  logic signed [DW-1:0] mix_i,
  input  logic signed [DW-1:0] mix_q,
  output logic                 fo_vld,
  output logic signed [DW-1:0] fo_i,
  output logic signed [DW-1:0] fo_q
);
  localparam int NT = 2*DEC - 1;
  localparam int LD = $clog2(DEC);
  localparam int SW = DW + 2*LD + 1;

  function automatic int coef(input int k);
    return DEC - ((k >= DEC-1) ? k - (DEC-1) : (DEC-1) - k);
  endfunction

  logic signed [DW-1:0] tap_i [NT];
  logic signed [DW-1:0] tap_q [NT];
  logic [LD-1:0]        cnt_q, cnt_d;
  logic                 dump_q, dump_d;
  logic signed [SW-1:0] sum_i, sum_q;

  always_comb begin
    dump_d = mix_vld && (cnt_q == LD'(DEC-1));
    cnt_d  = mix_vld ? cnt_q + 1'b1 : cnt_q;
    sum_i  = '0;
    sum_q  = '0;
    for (int k = 0; k < NT; k++) begin
      sum_i = sum_i + SW'(tap_i[k]) * SW'(coef(k));
      sum_q = sum_q + SW'(tap_q[k]) * SW'(coef(k));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NT; k++) begin
        tap_i[k] <= '0;
        tap_q[k] <= '0;
      end
      cnt_q  <= '0;
      dump_q <= 1'b0;
      fo_vld <= 1'b0;
      fo_i   <= '0;
      fo_q   <= '0;
    end else begin
      cnt_q  <= cnt_d;
      dump_q <= dump_d;
      fo_vld <= dump_q;
      if (mix_vld) begin
        tap_i[0] <= mix_i;
        tap_q[0] <= mix_q;
        for (int k = 1; k < NT; k++) begin
          tap_i[k] <= tap_i[k-1];
          tap_q[k] <= tap_q[k-1];
        end
      end
      if (dump_q) begin
        fo_i <= DW'(sum_i >>> (2*LD));
        fo_q <= DW'(sum_q >>> (2*LD));
      end
    end
  end

  // R5
  dump_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dump_q |=> !dump_q);
endmodule

// File: rtl/bf_ddc_rotgain.sv
module bf_ddc_rotgain #(
  parameter int DW = 16,
  parameter int AW = 10,
  parameter int GW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fo_vld,
  input  logic signed [DW-1:0] fo_i,
  input  logic signed [DW-1:0] fo_q,
  input  logic [AW-1:0]        phs,
  input  logic [GW-1:0]        gain,
  output logic                 out_vld,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);
  localparam int RW = DW + 2;
  localparam int SW = 2*DW + 1;
  localparam int PW = RW + GW + 1;

  function automatic logic signed [DW-1:0] clip(input logic signed [PW-1:0] v);
    if (v > PW'((1 << (DW-1)) - 1))  return DW'((1 << (DW-1)) - 1);
    if (v < PW'(-(1 << (DW-1))))     return DW'(-(1 << (DW-1)));
    return DW'(v);
  endfunction

  logic signed [DW-1:0] rc, rs;
  logic signed [SW-1:0] s_i, s_q;
  logic signed [RW-1:0] r_i, r_q;
  logic [GW-1:0]        g_q;
  logic                 r_vld;
  logic signed [PW-1:0] g_i, g_qd;

  bf_ddc_trig #(.AW(AW), .OW(DW)) i_steer (.ang(phs), .cos_o(rc), .sin_o(rs));

  always_comb begin
    s_i  = SW'(fo_i) * SW'(rc) - SW'(fo_q) * SW'(rs);
    s_q  = SW'(fo_i) * SW'(rs) + SW'(fo_q) * SW'(rc);
    g_i  = (PW'(r_i) * PW'($signed({1'b0, g_q}))) >>> (GW-1);
    g_qd = (PW'(r_q) * PW'($signed({1'b0, g_q}))) >>> (GW-1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_i     <= '0;
      r_q     <= '0;
      g_q     <= '0;
      r_vld   <= 1'b0;
      out_vld <= 1'b0;
      out_i   <= '0;
      out_q   <= '0;
    end else begin
      r_vld   <= fo_vld;
      out_vld <= r_vld;
      if (fo_vld) begin
        r_i <= RW'(s_i >>> (DW-1));
        r_q <= RW'(s_q >>> (DW-1));
        g_q <= gain;
      end
      if (r_vld) begin
        out_i <= clip(g_i);
        out_q <= clip(g_qd);
      end
    end
  end

  // R8
  gain_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fo_vld |=> $stable(g_q));
  // R7
  gain_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_vld && g_q == '0) |=> (out_i == '0 && out_q == '0));
  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> ($stable(out_i) && $stable(out_q)));
endmodule

// File: rtl/bf_ddc.sv
module bf_ddc #(
  parameter int DW  = 16,
  parameter int PHW = 32,
  parameter int AW  = 10,
  parameter int GW  = 16,
  parameter int DEC = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_vld,
  input  logic [DW-1:0]  in_data,
  input  logic           cfg_we,
  input  logic [1:0]     cfg_addr,
  input  logic [PHW-1:0] cfg_wdata,
  output logic           out_vld,
  output logic [DW-1:0]  out_i,
  output logic [DW-1:0]  out_q
);
  import bf_ddc_pkg::*;

  logic [1:0]     rs_q;
  logic           rst_s_n;
  logic [PHW-1:0] tune_q, tune_d;
  logic [AW-1:0]  phs_q, phs_d;
  logic [GW-1:0]  gain_q, gain_d;
  cfg_sel_e       sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  always_comb begin
    sel    = cfg_sel_e'(cfg_addr);
    tune_d = tune_q;
    phs_d  = phs_q;
    gain_d = gain_q;
    if (cfg_we) begin
      case (sel)
        CFG_TUNE:  tune_d = cfg_wdata;
        CFG_PHASE: phs_d  = cfg_wdata[AW-1:0];
        CFG_GAIN:  gain_d = cfg_wdata[GW-1:0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      tune_q <= '0;
      phs_q  <= '0;
      gain_q <= GW'(1) << (GW-1);
    end else begin
      tune_q <= tune_d;
      phs_q  <= phs_d;
      gain_q <= gain_d;
    end
  end

  logic                 mix_vld, fo_vld, o_vld;
  logic signed [DW-1:0] mix_i, mix_q, fo_i, fo_q, o_i, o_q;

  bf_ddc_nco_mix #(.DW(DW), .PHW(PHW), .AW(AW)) i_nco (
    .clk(clk), .rst_n(rst_s_n), .in_vld(in_vld), .in_data(in_data),
    .tune(tune_q), .mix_vld(mix_vld), .mix_i(mix_i), .mix_q(mix_q));

  bf_ddc_fir_dec #(.DW(DW), .DEC(DEC)) i_fir (
    .clk(clk), .rst_n(rst_s_n), .mix_vld(mix_vld), .mix_i(mix_i), .mix_q(mix_q),
    .fo_vld(fo_vld), .fo_i(fo_i), .fo_q(fo_q));

  bf_ddc_rotgain #(.DW(DW), .AW(AW), .GW(GW)) i_rot (
    .clk(clk), .rst_n(rst_s_n), .fo_vld(fo_vld), .fo_i(fo_i), .fo_q(fo_q),
    .phs(phs_q), .gain(gain_q), .out_vld(o_vld), .out_i(o_i), .out_q(o_q));

  assign out_vld = o_vld;
  assign out_i   = o_i;
  assign out_q   = o_q;

  // R5
  out_gap_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    out_vld |=> !out_vld);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_s_n |-> (!out_vld && out_i == '0 && out_q == '0));
endmodule

// File: tb/test_bf_ddc.sv
module test_bf_ddc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [15:0] in_data = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        out_vld;
  logic [15:0] out_i, out_q;

  int checks = 0;
  int errors = 0;
  string cur_req = "R3";

  always #2 clk = ~clk;

  bf_ddc i_bf_ddc (.*);

  // ---------------- behavioural reference model ----------------
  longint m_hi[15];
  longint m_hq[15];
  longint m_acc, m_ftw, m_ph, m_g;
  int     m_cnt;
  longint cyc;
  longint fq_due[$], fq_i[$], fq_q[$];
  longint oq_due[$], oq_i[$], oq_q[$];
  longint last_i, last_q;

  function automatic longint tsin(input longint a);
    real v;
    v = 32767.0 * $sin(6.283185307179586 * real'(a % 1024) / 1024.0);
    return (v >= 0.0) ? longint'($rtoi(v + 0.5)) : -longint'($rtoi(-v + 0.5));
  endfunction

  function automatic longint tcos(input longint a);
    return tsin((a + 256) % 1024);
  endfunction

  function automatic longint sat16(input longint v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 15; k++) begin m_hi[k] = 0; m_hq[k] = 0; end
      m_acc = 0; m_ftw = 0; m_ph = 0; m_g = 32768; m_cnt = 0; cyc = 0;
      fq_due.delete(); fq_i.delete(); fq_q.delete();
      oq_due.delete(); oq_i.delete(); oq_q.delete();
    end else begin
      cyc++;
      if (fq_due.size() > 0 && fq_due[0] == cyc) begin
        longint fi, fq, c, s, ri, rq;
        fi = fq_i.pop_front(); fq = fq_q.pop_front(); void'(fq_due.pop_front());
        c = tcos(m_ph); s = tsin(m_ph);
        ri = (fi * c - fq * s) >>> 15;
        rq = (fi * s + fq * c) >>> 15;
        oq_due.push_back(cyc + 1);
        oq_i.push_back(sat16((ri * m_g) >>> 15));
        oq_q.push_back(sat16((rq * m_g) >>> 15));
      end
      if (in_vld) begin
        longint x, a, si, sq;
        x = longint'($signed(in_data));
        a = (m_acc >> 22) & 1023;
        for (int k = 14; k > 0; k--) begin m_hi[k] = m_hi[k-1]; m_hq[k] = m_hq[k-1]; end
        m_hi[0] = (x * tcos(a)) >>> 15;
        m_hq[0] = (x * -tsin(a)) >>> 15;
        m_acc = (m_acc + m_ftw) & 64'hFFFF_FFFF;
        m_cnt++;
        if (m_cnt == 8) begin
          m_cnt = 0; si = 0; sq = 0;
          for (int k = 0; k < 15; k++) begin
            longint h;
            h = 8 - ((k >= 7) ? k - 7 : 7 - k);
            si += h * m_hi[k]; sq += h * m_hq[k];
          end
          fq_due.push_back(cyc + 4);
          fq_i.push_back(si >>> 6);
          fq_q.push_back(sq >>> 6);
        end
      end
      if (cfg_we) begin
        case (cfg_addr)
          2'd0: m_ftw = longint'(cfg_wdata);
          2'd1: m_ph  = longint'(cfg_wdata[9:0]);
          2'd2: m_g   = longint'(cfg_wdata[15:0]);
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at model cycle %0d", req, act, exp, cyc);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      last_i = 0; last_q = 0;
    end else if (cyc > 0) begin
      bit ev;
      ev = (oq_due.size() > 0) && (oq_due[0] == cyc);
      chk(out_vld == ev, "R5", longint'(out_vld), longint'(ev));
      if (ev) begin
        longint ei, eq;
        ei = oq_i.pop_front(); eq = oq_q.pop_front(); void'(oq_due.pop_front());
        chk(longint'($signed(out_i)) == ei, cur_req, longint'($signed(out_i)), ei);
        chk(longint'($signed(out_q)) == eq, cur_req, longint'($signed(out_q)), eq);
        last_i = ei; last_q = eq;
      end else begin
        chk(longint'($signed(out_i)) == last_i, "R10", longint'($signed(out_i)), last_i);
        chk(longint'($signed(out_q)) == last_q, "R10", longint'($signed(out_q)), last_q);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input bit v, input logic [15:0] x, input bit we,
                      input logic [1:0] a, input logic [31:0] d);
    in_vld = v; in_data = x; cfg_we = we; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    in_vld = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    step(1'b0, 16'h0, 1'b1, a, d);
  endtask

  task automatic run(input int n, input int vpct, input int mode);
    for (int k = 0; k < n; k++) begin
      logic [15:0] x;
      x = (mode == 0) ? 16'd8000 : (mode == 1) ? 16'h7FFF :
          (mode == 2) ? 16'h8000 : 16'($urandom);
      step(($urandom % 100) < vpct, x, 1'b0, 2'd0, 32'd0);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: quiet during reset
    chk(out_vld == 1'b0 && out_i == '0 && out_q == '0, "R1", longint'(out_i), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_vld == 1'b0 && out_i == '0 && out_q == '0, "R1", longint'(out_q), 0);

    cur_req = "R3";  run(48, 100, 0);           // DC through zero-frequency LO
    cur_req = "R4";  run(40, 100, 3);           // random data, filter shape
    cur_req = "R2";  wr(2'd0, 32'h1000_0000); run(96, 100, 3);
    wr(2'd0, 32'h0123_4567); run(96, 100, 3);
    cur_req = "R5";  run(160, 45, 3);            // gapped input strobes
    cur_req = "R6";  wr(2'd1, 32'hFFFF_F155); run(64, 100, 3);
    wr(2'd1, 32'h0000_0300); run(64, 80, 3);
    cur_req = "R7";  wr(2'd0, 32'h0); wr(2'd1, 32'h0);
    wr(2'd2, 32'h0); run(40, 100, 3);           // zero gain
    wr(2'd2, 32'h0000_FFFF); run(48, 100, 1);   // positive saturation
    run(48, 100, 2);                             // negative saturation
    wr(2'd2, 32'h0000_4000); run(32, 100, 3);
    cur_req = "R8";
    wr(2'd0, 32'h0800_0001);
    for (int k = 0; k < 300; k++) begin
      logic [1:0] a;
      a = ($urandom % 2 == 0) ? 2'd1 : 2'd2;
      step(($urandom % 100) < 85, 16'($urandom), ($urandom % 4) == 0, a, $urandom);
    end
    cur_req = "R9";
    for (int k = 0; k < 200; k++) begin
      step(1'b1, 16'($urandom), ($urandom % 6) == 0,
           ($urandom % 3 == 0) ? 2'd0 : 2'd3, $urandom);
    end
    run(24, 0, 3);
    report();
  end
endmodule